// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Shortcut Mirroring

This block gathers level-sensitive interrupt requests from three banks and drives one normal interrupt line and one fast interrupt line. Bank 0 carries eight local sources. Banks 1 and 2 each carry 32 peripheral sources. Each bank can be masked through a pair of registers: one sets enable bits for each 1 written, the other clears them. The bank 0 status word also gathers the other two banks. One bit per peripheral bank says "something non-shortcut is pending and enabled there". A small, parameter-chosen group of peripheral sources is also mirrored directly into bank 0 as shortcut bits.

Shortcut sources never raise their bank's summary bit. The summary bits cannot be masked at all. Shortcut bits are masked only through their home bank, so bank 0 mask writes at those positions are discarded. A fast-routing control register picks any single raw source by a flat index and steers it to the fast line, whatever the enable registers hold.

Top module: `bkic_top`

## Requirements
- R1: Status reads show raw source levels. Address 1 returns the bank 1 inputs and address 2 the bank 2 inputs. Bits 7:0 at address 0 return the bank 0 inputs. Bits 31:21 at address 0 read zero.
- R2: Bank 0 status bit 8 is 1 exactly when some bank 1 source outside the shortcut group is high and enabled. Bit 9 does the same for bank 2. A shortcut source never sets either bit.
- R3: Bank 0 status bit 10+k equals bank 1 source SC1[k] AND its bank 1 enable, with SC1 = {7, 9, 10, 18, 19}. Bit 15+k does the same for bank 2 source SC2[k], with SC2 = {21, 22, 23, 24, 25, 30}.
- R4: The enable addresses are 3, 4 and 5 (banks 0, 1, 2); each 1 written there sets that enable bit. The disable addresses are 6, 7 and 8; each 1 written there clears that enable bit. Zero bits leave enables unchanged. Reads of either address return the bank's current enable mask.
- R5: Bank 0 enable and disable writes affect only bits 7:0. Bits 31:8 of the bank 0 mask always read zero. Summary and shortcut bits reach the interrupt line whatever bank 0 mask writes say.
- R6: `irq` is registered. It is high one cycle after any of these is true: a bank 0 source is high and enabled, a summary bit is set, or a shortcut bit is set. Otherwise it is low.
- R7: The fast control register is at address 9. Bits 6:0 hold the source index and bit 7 is the fast enable. Bits 31:8 read zero.
- R8: `fiq` is registered. It is high one cycle after the fast enable is set while the raw source at the index is high. Indices 0–31 select bank 1, 32–63 bank 2, 64–71 bank 0, and 72–127 select nothing. Enable registers have no effect on `fiq`.
- R9: After reset all enables and the fast control register are zero, and `irq` and `fiq` are low.
- R10: Writes to addresses 0–2 or 10–15 change no register. Reads of addresses 10–15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_b0 | input | 8 | Bank 0 local level sources |
| src_b1 | input | 32 | Bank 1 peripheral level sources |
| src_b2 | input | 32 | Bank 2 peripheral level sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Registered normal interrupt |
| fiq | output | 1 | Registered fast interrupt |

## Verification
The bench sweeps every peripheral source under two enable masks. A design that let shortcut sources raise the summary bit, or that mirrored a wrong source position, shows a wrong bank 0 status word at once. Bank 0 disable writes at the summary and shortcut positions are checked against `irq`; a design that masked there would drop the line. All 128 fast indices are swept one-hot and then with the selected bit alone held low, with every enable cleared. This catches off-by-one bank ordering, wrap-around at indices 72 and above, and any gating of `fiq` by enables.

// File: rtl/bkic_pkg.sv
package bkic_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] RA_PEND0 = 4'd0;
    localparam logic [REG_AW-1:0] RA_PEND1 = 4'd1;
    localparam logic [REG_AW-1:0] RA_PEND2 = 4'd2;
    localparam logic [REG_AW-1:0] RA_EN0   = 4'd3;
    localparam logic [REG_AW-1:0] RA_EN1   = 4'd4;
    localparam logic [REG_AW-1:0] RA_EN2   = 4'd5;
    localparam logic [REG_AW-1:0] RA_DIS0  = 4'd6;
    localparam logic [REG_AW-1:0] RA_DIS1  = 4'd7;
    localparam logic [REG_AW-1:0] RA_DIS2  = 4'd8;
    localparam logic [REG_AW-1:0] RA_FIQC  = 4'd9;

    localparam int FIQ_IDX_W = 7;

    typedef struct packed {
        logic                 fen;
        logic [FIQ_IDX_W-1:0] idx;
    } fiq_ctl_t;

endpackage

// File: rtl/bkic_regs.sv
module bkic_regs
    import bkic_pkg::*;
#(
    parameter int NUM_B0 = 8,
    parameter int BANK_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_B0-1:0]    en0,
    output logic [BANK_W-1:0]    en1,
    output logic [BANK_W-1:0]    en2,
    output fiq_ctl_t             fc
);

    localparam int FC_W = $bits(fiq_ctl_t);

    typedef struct packed {
        logic [NUM_B0-1:0] en0;
        logic [BANK_W-1:0] en1;
        logic [BANK_W-1:0] en2;
        fiq_ctl_t          fc;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                RA_EN0:  st_d.en0 = st_q.en0 |  wr_data[NUM_B0-1:0];
                RA_EN1:  st_d.en1 = st_q.en1 |  wr_data[BANK_W-1:0];
                RA_EN2:  st_d.en2 = st_q.en2 |  wr_data[BANK_W-1:0];
                RA_DIS0: st_d.en0 = st_q.en0 & ~wr_data[NUM_B0-1:0];
                RA_DIS1: st_d.en1 = st_q.en1 & ~wr_data[BANK_W-1:0];
                RA_DIS2: st_d.en2 = st_q.en2 & ~wr_data[BANK_W-1:0];
                RA_FIQC: st_d.fc  = fiq_ctl_t'(wr_data[FC_W-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en0 = st_q.en0;
    assign en1 = st_q.en1;
    assign en2 = st_q.en2;
    assign fc  = st_q.fc;

    AST_EN1_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_EN1) |=> ((en1 & $past(wr_data[BANK_W-1:0])) == $past(wr_data[BANK_W-1:0]))); // R4

    AST_DIS2_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_DIS2) |=> ((en2 & $past(wr_data[BANK_W-1:0])) == '0)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr < RA_EN0 || wr_addr > RA_FIQC) |=> $stable(st_q)); // R10

endmodule

// File: rtl/bkic_bank0_map.sv
module bkic_bank0_map #(
    parameter int NUM_B0    = 8,
    parameter int BANK_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SRC_IDX_W = 5,
    parameter int N_SC1     = 5,
    parameter int N_SC2     = 6,
    parameter logic [N_SC1*SRC_IDX_W-1:0] SC1_MAP = {5'd19, 5'd18, 5'd10, 5'd9, 5'd7},
    parameter logic [N_SC2*SRC_IDX_W-1:0] SC2_MAP = {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21}
) (
    input  logic [NUM_B0-1:0] src_b0,
    input  logic [BANK_W-1:0] src_b1,
    input  logic [BANK_W-1:0] src_b2,
    input  logic [BANK_W-1:0] en1,
    input  logic [BANK_W-1:0] en2,
    output logic [DATA_W-1:0] pend0
);

    localparam int SUM1_POS = NUM_B0;
    localparam int SUM2_POS = NUM_B0 + 1;
    localparam int SC1_BASE = NUM_B0 + 2;
    localparam int SC2_BASE = SC1_BASE + N_SC1;

    logic [BANK_W-1:0] sc1_mask, sc2_mask;
    logic [N_SC1-1:0]  sc1_hit;
    logic [N_SC2-1:0]  sc2_hit;
    logic              sum1, sum2;

    // Membership masks of the shortcut groups, built from the parameter lists.
    always_comb begin
        sc1_mask = '0;
        for (int k = 0; k < N_SC1; k++)
            sc1_mask[SC1_MAP[k*SRC_IDX_W +: SRC_IDX_W]] = 1'b1;
        sc2_mask = '0;
        for (int k = 0; k < N_SC2; k++)
            sc2_mask[SC2_MAP[k*SRC_IDX_W +: SRC_IDX_W]] = 1'b1;
    end

    for (genvar k = 0; k < N_SC1; k++) begin : g_sc1
        localparam int SRC = int'(SC1_MAP[k*SRC_IDX_W +: SRC_IDX_W]);
        assign sc1_hit[k] = src_b1[SRC] & en1[SRC];
    end

    for (genvar k = 0; k < N_SC2; k++) begin : g_sc2
        localparam int SRC = int'(SC2_MAP[k*SRC_IDX_W +: SRC_IDX_W]);
        assign sc2_hit[k] = src_b2[SRC] & en2[SRC];
    end

    assign sum1 = |(src_b1 & en1 & ~sc1_mask);
    assign sum2 = |(src_b2 & en2 & ~sc2_mask);

    always_comb begin
        pend0                        = '0;
        pend0[NUM_B0-1:0]            = src_b0;
        pend0[SUM1_POS]              = sum1;
        pend0[SUM2_POS]              = sum2;
        pend0[SC1_BASE +: N_SC1]     = sc1_hit;
        pend0[SC2_BASE +: N_SC2]     = sc2_hit;
    end

endmodule

// File: rtl/bkic_fiq_sel.sv
module bkic_fiq_sel
    import bkic_pkg::*;
#(
    parameter int NUM_B0 = 8,
    parameter int BANK_W = 32
) (
    input  logic [NUM_B0-1:0]    src_b0,
    input  logic [BANK_W-1:0]    src_b1,
    input  logic [BANK_W-1:0]    src_b2,
    input  logic [FIQ_IDX_W-1:0] idx,
    output logic                 sel_bit
);

    localparam int RAW_W = 2*BANK_W + NUM_B0;
    localparam int PAD_W = 1 << FIQ_IDX_W;

    logic [RAW_W-1:0] raw;
    logic [PAD_W-1:0] raw_pad;

    // Flat order: bank 1 first, then bank 2, then bank 0; the rest is zero.
    assign raw     = {src_b0, src_b2, src_b1};
    assign raw_pad = PAD_W'(raw);
    assign sel_bit = raw_pad[idx];

endmodule

// File: rtl/bkic_top.sv
module bkic_top
    import bkic_pkg::*;
#(
    parameter int NUM_B0    = 8,
    parameter int BANK_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SRC_IDX_W = 5,
    parameter int N_SC1     = 5,
    parameter int N_SC2     = 6,
    parameter logic [N_SC1*SRC_IDX_W-1:0] SC1_MAP = {5'd19, 5'd18, 5'd10, 5'd9, 5'd7},
    parameter logic [N_SC2*SRC_IDX_W-1:0] SC2_MAP = {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_B0-1:0] src_b0,
    input  logic [BANK_W-1:0] src_b1,
    input  logic [BANK_W-1:0] src_b2,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              fiq
);

    localparam int SUM1_POS = NUM_B0;
    localparam int SUM2_POS = NUM_B0 + 1;
    localparam int SC1_BASE = NUM_B0 + 2;
    localparam int SC2_BASE = SC1_BASE + N_SC1;

    typedef struct packed {
        logic irq;
        logic fiq;
    } out_t;

    logic [NUM_B0-1:0] en0;
    logic [BANK_W-1:0] en1, en2;
    fiq_ctl_t          fc;
    logic [DATA_W-1:0] pend0;
    logic              fiq_bit;
    out_t              out_d, out_q;

    bkic_regs #(
        .NUM_B0 (NUM_B0),
        .BANK_W (BANK_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en0     (en0),
        .en1     (en1),
        .en2     (en2),
        .fc      (fc)
    );

    bkic_bank0_map #(
        .NUM_B0    (NUM_B0),
        .BANK_W    (BANK_W),
        .DATA_W    (DATA_W),
        .SRC_IDX_W (SRC_IDX_W),
        .N_SC1     (N_SC1),
        .N_SC2     (N_SC2),
        .SC1_MAP   (SC1_MAP),
        .SC2_MAP   (SC2_MAP)
    ) map_i (
        .src_b0 (src_b0),
        .src_b1 (src_b1),
        .src_b2 (src_b2),
        .en1    (en1),
        .en2    (en2),
        .pend0  (pend0)
    );

    bkic_fiq_sel #(
        .NUM_B0 (NUM_B0),
        .BANK_W (BANK_W)
    ) fsel_i (
        .src_b0  (src_b0),
        .src_b1  (src_b1),
        .src_b2  (src_b2),
        .idx     (fc.idx),
        .sel_bit (fiq_bit)
    );

    // Local bits are masked by bank 0; summary and shortcut bits are not.
    always_comb begin
        out_d.irq = (|(pend0[NUM_B0-1:0] & en0)) | (|pend0[DATA_W-1:NUM_B0]);
        out_d.fiq = fc.fen & fiq_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq = out_q.irq;
    assign fiq = out_q.fiq;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_PEND0:         rd_data = pend0;
            RA_PEND1:         rd_data = DATA_W'(src_b1);
            RA_PEND2:         rd_data = DATA_W'(src_b2);
            RA_EN0, RA_DIS0:  rd_data = DATA_W'(en0);
            RA_EN1, RA_DIS1:  rd_data = DATA_W'(en1);
            RA_EN2, RA_DIS2:  rd_data = DATA_W'(en2);
            RA_FIQC:          rd_data = DATA_W'(fc);
            default:          ;
        endcase
    end

    AST_B1_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en1 == '0) |-> (!pend0[SUM1_POS] && pend0[SC1_BASE +: N_SC1] == '0)); // R2

    AST_B2_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en2 == '0) |-> (!pend0[SUM2_POS] && pend0[SC2_BASE +: N_SC2] == '0)); // R3

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (src_b0 == '0 && src_b1 == '0 && src_b2 == '0) |=> !irq); // R6

    AST_FIQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!fc.fen) |=> !fiq); // R8

endmodule

// File: tb/bkic_top_tb_top.sv
module bkic_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_b0 = '0;
    logic [31:0] src_b1 = '0;
    logic [31:0] src_b2 = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, fiq;

    always #4 clk = ~clk;

    bkic_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_b0(src_b0), .src_b1(src_b1), .src_b2(src_b2),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .fiq(fiq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int SC1_T [5] = '{7, 9, 10, 18, 19};
    int SC2_T [6] = '{21, 22, 23, 24, 25, 30};

    logic [7:0]  m_en0 = '0;
    logic [31:0] m_en1 = '0;
    logic [31:0] m_en2 = '0;
    logic [7:0]  m_fc  = '0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int sc_pos1(input int i);
        for (int k = 0; k < 5; k++) if (SC1_T[k] == i) return k;
        return -1;
    endfunction

    function automatic int sc_pos2(input int i);
        for (int k = 0; k < 6; k++) if (SC2_T[k] == i) return k;
        return -1;
    endfunction

    function automatic logic [31:0] exp_pend0();
        logic [31:0] r = {24'd0, src_b0};
        for (int i = 0; i < 32; i++) begin
            if (src_b1[i] && m_en1[i]) begin
                if (sc_pos1(i) >= 0) r[10 + sc_pos1(i)] = 1'b1;
                else                 r[8] = 1'b1;
            end
            if (src_b2[i] && m_en2[i]) begin
                if (sc_pos2(i) >= 0) r[15 + sc_pos2(i)] = 1'b1;
                else                 r[9] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic exp_irq();
        logic [31:0] p = exp_pend0();
        return (|(p[7:0] & m_en0)) | (|p[31:8]);
    endfunction

    function automatic logic exp_fiq();
        int idx = int'(m_fc[6:0]);
        logic b;
        if (idx < 32)      b = src_b1[idx];
        else if (idx < 64) b = src_b2[idx - 32];
        else if (idx < 72) b = src_b0[idx - 64];
        else               b = 1'b0;
        return m_fc[7] & b;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            4'd3: m_en0 = m_en0 | d[7:0];
            4'd4: m_en1 = m_en1 | d;
            4'd5: m_en2 = m_en2 | d;
            4'd6: m_en0 = m_en0 & ~d[7:0];
            4'd7: m_en1 = m_en1 & ~d;
            4'd8: m_en2 = m_en2 & ~d;
            4'd9: m_fc  = d[7:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_raw(input logic [71:0] r);
        src_b1 = r[31:0];
        src_b2 = r[63:32];
        src_b0 = r[71:64];
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        rd(4'd3, d); chk("R9", "en0 after reset", d, 32'd0);
        rd(4'd4, d); chk("R9", "en1 after reset", d, 32'd0);
        rd(4'd5, d); chk("R9", "en2 after reset", d, 32'd0);
        rd(4'd9, d); chk("R9", "fiqc after reset", d, 32'd0);
        chk("R9", "irq after reset", {31'd0, irq}, 32'd0);
        chk("R9", "fiq after reset", {31'd0, fiq}, 32'd0);

        // R4: set/clear semantics and readback from both addresses
        wr(4'd4, 32'h0F0F_00F0);
        wr(4'd4, 32'h0000_0F01);
        rd(4'd4, d); chk("R4", "en1 after two sets", d, 32'h0F0F_0FF1);
        wr(4'd7, 32'h0000_00F0);
        rd(4'd4, d); chk("R4", "en1 after clear", d, 32'h0F0F_0F01);
        rd(4'd7, d); chk("R4", "dis1 readback", d, 32'h0F0F_0F01);
        wr(4'd5, 32'hA000_0003);
        wr(4'd8, 32'h2000_0001);
        rd(4'd8, d); chk("R4", "dis2 readback", d, 32'h8000_0002);
        wr(4'd3, 32'h0000_0011);
        wr(4'd6, 32'h0000_0001);
        rd(4'd6, d); chk("R4", "dis0 readback", d, 32'h0000_0010);

        // R5: bank 0 mask only has bits 7:0
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd3, d); chk("R5", "en0 upper bits", d, 32'h0000_00FF);

        // R10: writes to status and unused addresses change nothing
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd2, 32'h0000_0000);
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd3, d); chk("R10", "en0 kept", d, 32'h0000_00FF);
        rd(4'd4, d); chk("R10", "en1 kept", d, 32'h0F0F_0F01);
        rd(4'd5, d); chk("R10", "en2 kept", d, 32'h8000_0002);
        rd(4'd9, d); chk("R10", "fiqc kept", d, 32'd0);
        rd(4'd12, d); chk("R10", "unused read", d, 32'd0);

        // R1 R2 R3 R6: sweep every peripheral source under two masks
        for (int pass = 0; pass < 2; pass++) begin
            wr(4'd7, 32'hFFFF_FFFF);
            wr(4'd8, 32'hFFFF_FFFF);
            wr(4'd4, pass == 0 ? 32'hFFFF_FFFF : 32'h5A5A_C3C3);
            wr(4'd5, pass == 0 ? 32'hFFFF_FFFF : 32'hC35A_5AC3);
            for (int i = 0; i < 32; i++) begin
                set_raw(72'd0);
                src_b1 = 32'd1 << i;
                settle();
                rd(4'd1, d); chk("R1", "bank1 status", d, src_b1);
                rd(4'd0, d);
                chk(sc_pos1(i) >= 0 ? "R3" : "R2", "bank0 status from bank1", d, exp_pend0());
                chk("R6", "irq from bank1", {31'd0, irq}, {31'd0, exp_irq()});
                set_raw(72'd0);
                src_b2 = 32'd1 << i;
                settle();
                rd(4'd2, d); chk("R1", "bank2 status", d, src_b2);
                rd(4'd0, d);
                chk(sc_pos2(i) >= 0 ? "R3" : "R2", "bank0 status from bank2", d, exp_pend0());
                chk("R6", "irq from bank2", {31'd0, irq}, {31'd0, exp_irq()});
            end
        end

        // R2: shortcut plus ordinary source together
        set_raw(72'd0);
        wr(4'd4, 32'hFFFF_FFFF);
        src_b1 = (32'd1 << 7) | (32'd1 << 3);
        settle();
        rd(4'd0, d); chk("R2", "shortcut and ordinary", d, 32'h0000_0500);

        // R1 R6: bank 0 sources under mask 0xA5
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd3, 32'h0000_00A5);
        for (int j = 0; j < 8; j++) begin
            set_raw(72'd0);
            src_b0 = 8'd1 << j;
            settle();
            rd(4'd0, d); chk("R1", "bank0 local status", d, {24'd0, src_b0});
            chk("R6", "irq from bank0", {31'd0, irq}, {31'd0, exp_irq()});
        end

        // R5: bank 0 writes cannot mask summary or shortcut bits
        set_raw(72'd0);
        wr(4'd4, 32'hFFFF_FFFF);
        src_b1 = 32'd1 << 7;
        wr(4'd6, 32'hFFFF_FFFF);
        settle();
        chk("R5", "shortcut irq after bank0 disable", {31'd0, irq}, 32'd1);
        rd(4'd0, d); chk("R5", "shortcut bit kept", d, 32'h0000_0400);
        src_b1 = 32'd1 << 0;
        wr(4'd6, 32'h001F_FF00);
        settle();
        chk("R5", "summary irq after bank0 disable", {31'd0, irq}, 32'd1);
        src_b1 = 32'd1 << 7;
        wr(4'd7, 32'd1 << 7);
        settle();
        chk("R3", "shortcut masked at home bank", {31'd0, irq}, 32'd0);
        rd(4'd0, d); chk("R3", "shortcut bit cleared", d, 32'd0);

        // R7: control register width
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, d); chk("R7", "fiqc upper zero", d, 32'h0000_00FF);

        // R8: every index, all enables off
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        for (int x = 0; x < 128; x++) begin
            wr(4'd9, 32'h80 | x);
            set_raw(x < 72 ? (72'd1 << x) : {72{1'b1}});
            settle();
            chk("R8", "fiq one-hot", {31'd0, fiq}, {31'd0, exp_fiq()});
            set_raw(x < 72 ? ~(72'd1 << x) : 72'd0);
            settle();
            chk("R8", "fiq selected low", {31'd0, fiq}, 32'd0);
        end
        set_raw({72{1'b1}});
        wr(4'd9, 32'h0000_0005);
        settle();
        chk("R8", "fiq enable clear", {31'd0, fiq}, 32'd0);
        chk("R6", "irq with all enables off", {31'd0, irq}, 32'd0);
        wr(4'd9, 32'h0000_0085);
        settle();
        chk("R8", "fiq index 5 enabled", {31'd0, fiq}, 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule